// File: doc/BRIEF.md
# Two-Channel DAC Command Processor for an I2C Write Path

This block turns the byte events of an I2C slave front end into register updates for a two-channel digital-to-analog converter. The front end reports START, STOP, the address byte and each written data byte. The block accepts a transaction in two cases. The first is that the address equals a fixed global address. The second is that it equals the device address, which three ternary configuration pins select. After the address, the block reads one command byte. It then assembles the following data bytes, in pairs, into 16-bit words. For each complete word it applies the command to the channels that the command byte selects.

Each channel has three pieces of state: an input register, an output register that would drive the converter, and a power-down flag. A parameter sets the resolution to 16, 14 or 12 bits. At the lower resolutions the code is the upper part of each 16-bit word. Bit-level bus handling, reads and the analog side are done elsewhere.

Top module: `i2c_dual_dac_cmd`

## Requirements
- R1: After reset the block is idle, and all input and output registers and both power-down flags are 0.
- R2: A write to the 7-bit address 0x73 (address byte bits 7:1, bit 0 = 0 for write) is accepted whatever the pin setting.
- R3: Each pin digit is 2 bits: 0 = low, 1 = floating, 2 = high. Pin bits 5:4 are CA2, 3:2 are CA1 and 1:0 are CA0. The device address matches when address bits {6,5,4,1,0} equal 9*CA2 + 3*CA1 + CA0 + 4, with address bits 3:2 ignored. A digit code of 3 disables the device match. A read, or an address that matches nothing, is ignored until the next START.
- R4: In the first data byte, bits 7:4 are the command and bits 3:0 the channel. Channel 0x0 is A, 0x1 is B and 0xF is both. Any other channel code makes the transaction change nothing.
- R5: Data bytes pair up MSB first into 16-bit words. Each word is executed, and further pairs in the same transaction are further words. The code is the word shifted right by 16 minus the resolution.
- R6: Command 0x0 loads the code into the input register of each selected channel and changes nothing else.
- R7: Command 0x1 copies the input register to the output register of each selected channel and clears its power-down flag. The word's value is not used.
- R8: Command 0x3 loads the code into both the input and the output register of each selected channel and clears its power-down flag.
- R9: Command 0x4 sets the power-down flag of each selected channel and leaves its registers unchanged.
- R10: Command 0xF and every command code not listed above change nothing.
- R11: STOP returns the block to idle from any phase, and a lone trailing byte is then discarded. Data bytes outside a transaction are ignored. A repeated START restarts the address phase.
- R12: The registers change at the clock edge that takes in the second byte of a word, and at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_digits | input | 6 | Ternary address pins CA2, CA1, CA0, 2 bits each |
| ev_start | input | 1 | One-cycle START event |
| ev_stop | input | 1 | One-cycle STOP event |
| ev_addr | input | 1 | One-cycle address-byte event |
| ev_wr | input | 1 | One-cycle written-data-byte event |
| ev_byte | input | 8 | Byte for ev_addr or ev_wr |
| in_code_a | output | RES_BITS | Channel A input register |
| out_code_a | output | RES_BITS | Channel A output register |
| pd_a | output | 1 | Channel A power-down flag |
| in_code_b | output | RES_BITS | Channel B input register |
| out_code_b | output | RES_BITS | Channel B output register |
| pd_b | output | 1 | Channel B power-down flag |

## Verification
There is exactly one register stage between an event and its result. A word's effect appears right after the edge that samples its second byte, and everything else leaves the registers untouched. The bench drives each event for one cycle starting at a falling edge. It compares the outputs at the next falling edge, just after the sampling edge. Within a multi-byte transaction it checks after the first byte of a word that nothing has moved yet, and after the second byte that the word has landed. A second instance built for 12 bits is fed the same stimulus, which checks how codes are taken from the upper bits of each word.

// File: rtl/dac_cmd_pkg.sv
// Shared constants and types for the two-channel DAC command processor.
// Assumes a 16-bit data word and two channels.
package dac_cmd_pkg;
    localparam int WORD_W = 16;
    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_SKIP
    } txn_state_t;

    localparam logic [3:0] OP_WRITE      = 4'h0;
    localparam logic [3:0] OP_UPDATE     = 4'h1;
    localparam logic [3:0] OP_WRITE_UPD  = 4'h3;
    localparam logic [3:0] OP_POWER_DOWN = 4'h4;
    localparam logic [3:0] OP_NOP        = 4'hF;
    localparam logic [3:0] CH_ALL        = 4'hF;

    // True when channel field ch addresses channel number idx
    function automatic logic chan_hits(input logic [3:0] ch, input int idx);
        return (ch == CH_ALL) || (ch == 4'(idx));
    endfunction
endpackage

// File: rtl/dac_addr_match.sv
// Address comparator. It compares the address byte (bits 7:1 address,
// bit 0 read flag) with the global address and with the device address
// that the three ternary pin digits give. Purely combinational.
// Assumes pin digits 0..2; a digit of 3 disables the device match.
module dac_addr_match #(
    parameter logic [6:0] GLOBAL_ADDR = 7'h73,
    parameter int         DEV_OFFSET  = 4
) (
    input  logic [7:0] addr_byte,
    input  logic [5:0] pin_digits,
    output logic       hit
);
    logic [6:0] a7;
    logic [1:0] dg2, dg1, dg0;
    logic       digits_ok;
    logic [4:0] dev_val;
    logic [4:0] packed_addr;

    // Decode the pins into a base-3 value and compare it with the packed address bits
    always_comb begin
        a7          = addr_byte[7:1];
        dg2         = pin_digits[5:4];
        dg1         = pin_digits[3:2];
        dg0         = pin_digits[1:0];
        digits_ok   = (dg2 != 2'd3) && (dg1 != 2'd3) && (dg0 != 2'd3);
        dev_val     = 5'(dg2) * 5'd9 + 5'(dg1) * 5'd3 + 5'(dg0) + 5'(DEV_OFFSET);
        packed_addr = {a7[6], a7[5], a7[4], a7[1], a7[0]};
        hit = !addr_byte[0] &&
              ((a7 == GLOBAL_ADDR) || (digits_ok && (packed_addr == dev_val)));
    end
endmodule

// File: rtl/dac_txn_fsm.sv
// Transaction sequencer. It follows the START / address / command / data
// phases, latches the command byte and pairs the data bytes into words.
// word_valid is combinational, high in the cycle the second byte of a word arrives.
// Assumes at most one event per cycle; START takes priority over STOP.
module dac_txn_fsm
    import dac_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_start,
    input  logic        ev_stop,
    input  logic        ev_addr,
    input  logic        ev_wr,
    input  logic [7:0]  ev_byte,
    input  logic        addr_hit,
    output txn_state_t  state,
    output logic [3:0]  op,
    output logic [3:0]  chan,
    output logic        word_valid,
    output logic [WORD_W-1:0] word
);
    logic [7:0] msb_q;
    logic       half_q;

    // Phase tracking, command latch and byte pairing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op     <= OP_NOP;
            chan   <= 4'h0;
            msb_q  <= 8'h00;
            half_q <= 1'b0;
        end else if (ev_start) begin
            state  <= ST_ADDR;
            half_q <= 1'b0;
        end else if (ev_stop) begin
            state  <= ST_IDLE;
            half_q <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (ev_addr) state <= addr_hit ? ST_CMD : ST_SKIP;
                ST_CMD: if (ev_wr) begin
                    op     <= ev_byte[7:4];
                    chan   <= ev_byte[3:0];
                    half_q <= 1'b0;
                    state  <= ST_DATA;
                end
                ST_DATA: if (ev_wr) begin
                    if (!half_q) msb_q <= ev_byte;
                    half_q <= !half_q;
                end
                default: ;
            endcase
        end
    end

    // Word completes on the second byte of a pair
    always_comb begin
        word_valid = (state == ST_DATA) && ev_wr && half_q && !ev_start && !ev_stop;
        word       = {msb_q, ev_byte};
    end
endmodule

// File: rtl/dac_chan.sv
// State of one converter channel: input register, output register and
// power-down flag. It applies one command per completed word when selected.
// Assumes code is already reduced to RES_BITS.
module dac_chan
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic                sel,
    input  logic [3:0]          op,
    input  logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] in_code,
    output logic [RES_BITS-1:0] out_code,
    output logic                pd
);
    // Execute the latched command on this channel when a word completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_code  <= '0;
            out_code <= '0;
            pd       <= 1'b0;
        end else if (word_valid && sel) begin
            case (op)
                OP_WRITE: in_code <= code;
                OP_UPDATE: begin
                    out_code <= in_code;
                    pd       <= 1'b0;
                end
                OP_WRITE_UPD: begin
                    in_code  <= code;
                    out_code <= code;
                    pd       <= 1'b0;
                end
                OP_POWER_DOWN: pd <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_dual_dac_cmd.sv
// Top level of the two-channel DAC command processor. It takes byte events
// from an I2C slave front end and updates the per-channel registers.
// Assumes RES_BITS is 16, 14 or 12 and that the events are single-cycle pulses.
module i2c_dual_dac_cmd
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [5:0]          pin_digits,
    input  logic                ev_start,
    input  logic                ev_stop,
    input  logic                ev_addr,
    input  logic                ev_wr,
    input  logic [7:0]          ev_byte,
    output logic [RES_BITS-1:0] in_code_a,
    output logic [RES_BITS-1:0] out_code_a,
    output logic                pd_a,
    output logic [RES_BITS-1:0] in_code_b,
    output logic [RES_BITS-1:0] out_code_b,
    output logic                pd_b
);
    localparam int SHIFT = WORD_W - RES_BITS;

    logic                addr_hit;
    txn_state_t          fsm_state;
    logic [3:0]          op_q;
    logic [3:0]          chan_q;
    logic                word_valid;
    logic [WORD_W-1:0]   word;
    logic [RES_BITS-1:0] code;
    logic [NUM_CH-1:0]   sel_vec;
    logic [RES_BITS-1:0] in_arr  [NUM_CH];
    logic [RES_BITS-1:0] out_arr [NUM_CH];
    logic [NUM_CH-1:0]   pd_arr;

    dac_addr_match u_match (
        .addr_byte (ev_byte),
        .pin_digits(pin_digits),
        .hit       (addr_hit)
    );

    dac_txn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_addr   (ev_addr),
        .ev_wr     (ev_wr),
        .ev_byte   (ev_byte),
        .addr_hit  (addr_hit),
        .state     (fsm_state),
        .op        (op_q),
        .chan      (chan_q),
        .word_valid(word_valid),
        .word      (word)
    );

    // Upper RES_BITS of the word form the code
    always_comb code = word[WORD_W-1:SHIFT];

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        // Channel select from the latched channel field
        always_comb sel_vec[gi] = chan_hits(chan_q, gi);

        dac_chan #(.RES_BITS(RES_BITS)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_valid(word_valid),
            .sel       (sel_vec[gi]),
            .op        (op_q),
            .code      (code),
            .in_code   (in_arr[gi]),
            .out_code  (out_arr[gi]),
            .pd        (pd_arr[gi])
        );
    end

    // Map the channel array to the named ports
    always_comb begin
        in_code_a  = in_arr[0];
        out_code_a = out_arr[0];
        pd_a       = pd_arr[0];
        in_code_b  = in_arr[1];
        out_code_b = out_arr[1];
        pd_b       = pd_arr[1];
    end
endmodule

// File: rtl/dac_cmd_checker.sv
// Assertion checker for i2c_dual_dac_cmd, attached with bind.
module dac_cmd_checker
    import dac_cmd_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ev_start,
    input logic         ev_stop,
    input txn_state_t   state,
    input logic         word_valid,
    input logic [3:0]   op,
    input logic [1:0]   sel,
    input logic [W-1:0] in_a,
    input logic [W-1:0] out_a,
    input logic         pd_a,
    input logic [W-1:0] in_b,
    input logic [W-1:0] out_b,
    input logic         pd_b
);
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop && !ev_start |=> state == ST_IDLE);

    p_word_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> state == ST_DATA);

    p_update_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && op == OP_UPDATE && sel[0] |=> out_a == $past(in_a) && !pd_a);

    p_update_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && op == OP_UPDATE && sel[1] |=> out_b == $past(in_b) && !pd_b);

    p_pd_keeps_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && op == OP_POWER_DOWN && sel[0] |=> pd_a && $stable(in_a) && $stable(out_a));

    p_unselected_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !sel[0] |=> $stable(in_a) && $stable(out_a) && $stable(pd_a));

    p_only_on_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(in_a) && $stable(out_a) && $stable(pd_a)
                        && $stable(in_b) && $stable(out_b) && $stable(pd_b));
endmodule

bind i2c_dual_dac_cmd dac_cmd_checker #(.W(RES_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .state     (fsm_state),
    .word_valid(word_valid),
    .op        (op_q),
    .sel       (sel_vec),
    .in_a      (in_code_a),
    .out_a     (out_code_a),
    .pd_a      (pd_a),
    .in_b      (in_code_b),
    .out_b     (out_code_b),
    .pd_b      (pd_b)
);

// File: tb/tb_i2c_dual_dac_cmd.sv
`timescale 1ns/1ps
module tb_i2c_dual_dac_cmd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pins = {2'd2, 2'd1, 2'd0};   // device address 0x61
    logic        ev_start = 0, ev_stop = 0, ev_addr = 0, ev_wr = 0;
    logic [7:0]  ev_byte = 8'h00;
    logic [15:0] in_a, out_a, in_b, out_b;
    logic        pd_a, pd_b;
    logic [11:0] lo_in_a, lo_out_a, lo_in_b, lo_out_b;
    logic        lo_pd_a, lo_pd_b;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [6:0] DEV = 7'h61;

    always #2.5 clk = ~clk;

    i2c_dual_dac_cmd #(.RES_BITS(16)) dut (
        .clk(clk), .rst_n(rst_n), .pin_digits(pins),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr(ev_addr), .ev_wr(ev_wr),
        .ev_byte(ev_byte),
        .in_code_a(in_a), .out_code_a(out_a), .pd_a(pd_a),
        .in_code_b(in_b), .out_code_b(out_b), .pd_b(pd_b)
    );

    i2c_dual_dac_cmd #(.RES_BITS(12)) dut_lo (
        .clk(clk), .rst_n(rst_n), .pin_digits(pins),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr(ev_addr), .ev_wr(ev_wr),
        .ev_byte(ev_byte),
        .in_code_a(lo_in_a), .out_code_a(lo_out_a), .pd_a(lo_pd_a),
        .in_code_b(lo_in_b), .out_code_b(lo_out_b), .pd_b(lo_pd_b)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0;
    endtask
    task automatic do_stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
    endtask
    task automatic do_addr(input logic [6:0] a, input logic rd);
        @(negedge clk); ev_addr = 1; ev_byte = {a, rd};
        @(negedge clk); ev_addr = 0;
    endtask
    task automatic do_wr(input logic [7:0] b);
        @(negedge clk); ev_wr = 1; ev_byte = b;
        @(negedge clk); ev_wr = 0;
    endtask
    task automatic txn(input logic [6:0] a, input logic [7:0] cmd, input logic [15:0] w);
        do_start(); do_addr(a, 1'b0); do_wr(cmd); do_wr(w[15:8]); do_wr(w[7:0]); do_stop();
    endtask

    task automatic t_reset();
        chk("R1 in_a", in_a, 0);   chk("R1 out_a", out_a, 0); chk("R1 pd_a", 16'(pd_a), 0);
        chk("R1 in_b", in_b, 0);   chk("R1 out_b", out_b, 0); chk("R1 pd_b", 16'(pd_b), 0);
    endtask

    task automatic t_write_input();
        txn(DEV, 8'h00, 16'h1234);
        chk("R6 in_a", in_a, 16'h1234); chk("R6 out_a", out_a, 0); chk("R6 in_b", in_b, 0);
        chk("R5 lo in_a", 16'(lo_in_a), 16'h0123);
        chk("R3 device match", in_a, 16'h1234);
    endtask

    task automatic t_update_both();
        txn(DEV, 8'h1F, 16'h0000);
        chk("R7 out_a", out_a, 16'h1234); chk("R7 out_b", out_b, 0);
        chk("R7 in_a", in_a, 16'h1234);   chk("R7 pd_a", 16'(pd_a), 0);
    endtask

    task automatic t_global_wpu();
        txn(7'h73, 8'h31, 16'hABCD);
        chk("R2 R8 in_b", in_b, 16'hABCD); chk("R8 out_b", out_b, 16'hABCD);
        chk("R8 in_a", in_a, 16'h1234);    chk("R5 lo out_b", 16'(lo_out_b), 16'h0ABC);
    endtask

    task automatic t_power_down();
        txn(DEV, 8'h4F, 16'h0000);
        chk("R9 pd_a", 16'(pd_a), 1); chk("R9 pd_b", 16'(pd_b), 1);
        chk("R9 out_a", out_a, 16'h1234); chk("R9 out_b", out_b, 16'hABCD);
        chk("R9 in_a", in_a, 16'h1234);
        txn(DEV, 8'h10, 16'hFFFF);
        chk("R7 pd_a cleared", 16'(pd_a), 0); chk("R7 pd_b kept", 16'(pd_b), 1);
        chk("R7 word unused", out_a, 16'h1234);
    endtask

    task automatic t_mismatch();
        txn(7'h62, 8'h00, 16'h5555);
        chk("R3 other addr", in_a, 16'h1234);
        do_start(); do_addr(DEV, 1'b1); do_wr(8'h00); do_wr(8'h55); do_wr(8'h55); do_stop();
        chk("R3 read ignored", in_a, 16'h1234);
        pins = {2'd2, 2'd1, 2'd3};
        txn(DEV, 8'h00, 16'h5555);
        chk("R3 digit 3", in_a, 16'h1234);
        txn(7'h73, 8'h01, 16'h0F0F);
        chk("R2 global with digit 3", in_b, 16'h0F0F);
        pins = {2'd2, 2'd1, 2'd0};
        txn(DEV | 7'h0C, 8'h01, 16'hABCD);
        chk("R3 bits 3:2 ignored", in_b, 16'hABCD);
    endtask

    task automatic t_ignored_codes();
        txn(DEV, 8'h05, 16'h5555);
        chk("R4 bad chan a", in_a, 16'h1234); chk("R4 bad chan b", in_b, 16'hABCD);
        txn(DEV, 8'hF0, 16'h5555);
        chk("R10 nop", in_a, 16'h1234);
        txn(DEV, 8'h20, 16'h5555);
        chk("R10 unlisted in", in_a, 16'h1234); chk("R10 unlisted out", out_a, 16'h1234);
        chk("R10 pd_b", 16'(pd_b), 1);
    endtask

    task automatic t_multi_word_odd();
        do_start(); do_addr(DEV, 1'b0); do_wr(8'h00);
        do_wr(8'h11);
        chk("R12 no change on first byte", in_a, 16'h1234);
        do_wr(8'h11);
        chk("R12 change on second byte", in_a, 16'h1111);
        do_wr(8'h22); do_wr(8'h22);
        chk("R5 second word", in_a, 16'h2222);
        do_wr(8'h99);
        chk("R11 odd byte pending", in_a, 16'h2222);
        do_stop();
        chk("R11 odd byte dropped", in_a, 16'h2222);
        chk("R5 lo second word", 16'(lo_in_a), 16'h0222);
        do_start(); do_addr(DEV, 1'b0); do_wr(8'h00); do_wr(8'h77); do_stop();
        txn(DEV, 8'h00, 16'h0102);
        chk("R11 no carry of odd byte", in_a, 16'h0102);
    endtask

    task automatic t_stop_then_bytes();
        do_start(); do_addr(DEV, 1'b0); do_stop();
        do_wr(8'h00); do_wr(8'h33); do_wr(8'h33);
        chk("R11 bytes after stop", in_a, 16'h0102);
    endtask

    task automatic t_repeated_start();
        do_start(); do_addr(DEV, 1'b0); do_wr(8'h01); do_wr(8'h44);
        do_start(); do_addr(DEV, 1'b0); do_wr(8'h00); do_wr(8'h0A); do_wr(8'h0B); do_stop();
        chk("R11 repeated start in_a", in_a, 16'h0A0B);
        chk("R11 repeated start out_a", out_a, 16'h1234);
        chk("R5 lo repeated start", 16'(lo_in_a), 16'h00A0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_input();
        t_update_both();
        t_global_wpu();
        t_power_down();
        t_mismatch();
        t_ignored_codes();
        t_multi_word_odd();
        t_stop_then_bytes();
        t_repeated_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule